// File: doc/BRIEF.md
# Self-Timed Program Engine for a Serial Nonvolatile Word Store

This block sits behind the serial front end of a small nonvolatile word store. The front end decodes each instruction and hands it over as a one-cycle command strobe with an operation code, an address and a data word. The engine keeps a write-enable latch. It holds back any erase or write command until the chip select falls, and then runs a self-timed program cycle against a register-file model of the storage array. Cycle lengths are counted in system-clock cycles and set by parameters. The erase-all cycle is twice the single-word cycle, and the write-all cycle is twice the erase-all cycle.

While a cycle runs, the host can poll its progress. It drops chip select for at least a minimum number of clocks and raises it again. The serial data output is then driven low while the engine is busy and high once it has finished. The output goes back to high impedance when chip select falls. A separate read port gives access to the array at all times, whether programming is enabled or not. Reset stands in for the power-on inhibit.

Top module: `eeprom_prog_engine`

## Requirements
- R1: After reset, programming is disabled, nothing is pending, no cycle runs and the output enable `doOe` is 0.
- R2: Operation codes are 0 no-op, 1 enable programming, 2 disable programming, 3 erase word, 4 write word, 5 erase all, 6 write all, and 7 no-op. Codes 1 and 2 set and clear the enable latch. Codes 3 to 6 received while the latch is clear are discarded and start no cycle. The read port returns array contents whatever the latch state.
- R3: An accepted program command starts its cycle only on the first clock that samples `csIn` low after sampling it high. `busy` rises in the cycle after that clock.
- R4: A running cycle lasts WORD_CYC clocks for codes 3 and 4, 2*WORD_CYC for code 5 and 4*WORD_CYC for code 6. The length does not depend on `csIn` or on any further command.
- R5: Code 3 sets every bit of the addressed word to 1 and leaves all other words unchanged.
- R6: Code 4 first sets the addressed word to all ones, so that it reads all ones while busy. On the last cycle it stores the command data.
- R7: Code 5 leaves every word all ones. Code 6 first sweeps every word to all ones and then stores the command data in every word. Both need 2**AW <= 2*WORD_CYC.
- R8: When `csIn` rises after a cycle has been launched, and it was low for at least MIN_LOW_CYC sampled clocks, `doOe` becomes 1 and `doOut` shows 0 while busy and 1 when done. A rise after a shorter low time, or with no launch since the previous rise, leaves `doOe` at 0.
- R9: `doOe` returns to 0 in the cycle after a falling edge of `csIn` is sampled, and it is never 1 unless `csIn` was high at the previous clock.
- R10: Any command that arrives while a cycle is running or a program command is pending is ignored, including enable and disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| csIn | input | 1 | Chip select level, synchronous to clk |
| cmdValid | input | 1 | One-cycle strobe for a decoded command |
| cmdOp | input | 3 | Operation code (see R2) |
| cmdAddr | input | AW | Word address of the command |
| cmdData | input | DW | Data word of a write command |
| rdAddr | input | AW | Read port address |
| rdData | output | DW | Word at rdAddr |
| doOut | output | 1 | Ready (1) or busy (0) status bit |
| doOe | output | 1 | Drive enable for doOut; 0 means high impedance |

## Verification
The bench builds the engine with a 16-word by 8-bit array, a 10-clock word cycle and a 3-clock minimum low time. With these values a write-all cycle, including both of its 16-word sweeps, completes in 40 clocks. Each exact cycle length can then be measured by polling the status output, and the whole array can be compared after every operation. The small sizes also allow dozens of random enable, disable and program commands, with intruding commands injected mid-cycle, plus directed cases for a too-short chip select low time and for commands sent while programming is disabled.

// File: rtl/eeprom_prog_pkg.sv
package eeprom_prog_pkg;

  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_ENABLE    = 3'd1,
    OP_DISABLE   = 3'd2,
    OP_ERASE     = 3'd3,
    OP_WRITE     = 3'd4,
    OP_ERASE_ALL = 3'd5,
    OP_WRITE_ALL = 3'd6,
    OP_SPARE     = 3'd7
  } progOp_e;

  // Strobes from control to the storage datapath
  typedef struct packed {
    logic loadData;  // capture command data word
    logic wrEn;      // write one word this cycle
    logic wrOnes;    // write all ones instead of the data word
  } storeStrobe_t;

endpackage

// File: rtl/eeprom_prog_store.sv
module eeprom_prog_store
  import eeprom_prog_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  storeStrobe_t  strb,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] cmdData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] dataReg;

  always_ff @(posedge clk) begin
    if (rst) dataReg <= '0;
    else if (strb.loadData) dataReg <= cmdData;
  end

  // Array contents are nonvolatile: not cleared by reset
  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[wrAddr] <= strb.wrOnes ? {DW{1'b1}} : dataReg;
  end

  assign rdData = mem[rdAddr];

endmodule

// File: rtl/eeprom_prog_ctrl.sv
module eeprom_prog_ctrl
  import eeprom_prog_pkg::*;
#(
  parameter int AW          = 6,
  parameter int WORD_CYC    = 80,
  parameter int MIN_LOW_CYC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csIn,
  input  logic          cmdValid,
  input  logic [2:0]    cmdOp,
  input  logic [AW-1:0] cmdAddr,
  output storeStrobe_t  strb,
  output logic [AW-1:0] wrAddr,
  output logic          busy,
  output logic          doOut,
  output logic          doOe
);
  localparam int DEPTH    = 1 << AW;
  localparam int ERAL_CYC = 2 * WORD_CYC;
  localparam int TOTAL    = 4 * WORD_CYC;
  localparam int CW       = $clog2(TOTAL + 1);
  localparam int LW       = $clog2(MIN_LOW_CYC + 1);

  progOp_e       opIn, opReg;
  logic          csPrev, enLatch, pending, running, armed, statusOn;
  logic [AW-1:0] addrReg;
  logic [CW-1:0] elapsed, duration;
  logic [LW-1:0] lowCnt;
  logic          csFall, csRise, accept, progCmd, lastCycle;

  assign opIn      = progOp_e'(cmdOp);
  assign csFall    = csPrev & ~csIn;
  assign csRise    = ~csPrev & csIn;
  assign accept    = cmdValid & ~running & ~pending;
  assign progCmd   = opIn inside {OP_ERASE, OP_WRITE, OP_ERASE_ALL, OP_WRITE_ALL};

  always_comb begin
    case (opReg)
      OP_ERASE_ALL: duration = CW'(ERAL_CYC);
      OP_WRITE_ALL: duration = CW'(TOTAL);
      default:      duration = CW'(WORD_CYC);
    endcase
  end

  assign lastCycle = running && (elapsed == duration - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      csPrev   <= 1'b0;
      enLatch  <= 1'b0;
      pending  <= 1'b0;
      running  <= 1'b0;
      armed    <= 1'b0;
      statusOn <= 1'b0;
      opReg    <= OP_NOP;
      addrReg  <= '0;
      elapsed  <= '0;
      lowCnt   <= '0;
    end else begin
      csPrev <= csIn;
      if (accept) begin
        if (opIn == OP_ENABLE) enLatch <= 1'b1;
        else if (opIn == OP_DISABLE) enLatch <= 1'b0;
        else if (progCmd && enLatch) begin
          pending <= 1'b1;
          opReg   <= opIn;
          addrReg <= cmdAddr;
        end
      end
      if (pending && csFall) begin
        pending <= 1'b0;
        running <= 1'b1;
        elapsed <= '0;
        armed   <= 1'b1;
      end
      if (running) begin
        if (lastCycle) running <= 1'b0;
        else elapsed <= elapsed + 1'b1;
      end
      if (csIn) lowCnt <= '0;
      else if (lowCnt != LW'(MIN_LOW_CYC)) lowCnt <= lowCnt + 1'b1;
      if (csFall) statusOn <= 1'b0;
      else if (csRise) begin
        statusOn <= armed && (lowCnt == LW'(MIN_LOW_CYC));
        armed    <= 1'b0;
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.loadData = accept && progCmd && enLatch;
    wrAddr        = addrReg;
    if (running) begin
      case (opReg)
        OP_ERASE: begin
          strb.wrEn   = (elapsed == '0);
          strb.wrOnes = 1'b1;
        end
        OP_WRITE: begin
          strb.wrEn   = (elapsed == '0) || lastCycle;
          strb.wrOnes = (elapsed == '0);
        end
        OP_ERASE_ALL: begin
          strb.wrEn   = (elapsed < CW'(DEPTH));
          strb.wrOnes = 1'b1;
          wrAddr      = AW'(elapsed);
        end
        OP_WRITE_ALL: begin
          if (elapsed < CW'(DEPTH)) begin
            strb.wrEn   = 1'b1;
            strb.wrOnes = 1'b1;
            wrAddr      = AW'(elapsed);
          end else if (elapsed >= CW'(ERAL_CYC) && elapsed < CW'(ERAL_CYC + DEPTH)) begin
            strb.wrEn = 1'b1;
            wrAddr    = AW'(elapsed - CW'(ERAL_CYC));
          end
        end
        default: ;
      endcase
    end
  end

  assign busy  = running;
  assign doOe  = statusOn;
  assign doOut = ~running;

endmodule

// File: rtl/eeprom_prog_engine.sv
module eeprom_prog_engine
  import eeprom_prog_pkg::*;
#(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int WORD_CYC    = 80,
  parameter int MIN_LOW_CYC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csIn,
  input  logic          cmdValid,
  input  logic [2:0]    cmdOp,
  input  logic [AW-1:0] cmdAddr,
  input  logic [DW-1:0] cmdData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData,
  output logic          doOut,
  output logic          doOe
);
  storeStrobe_t  strb;
  logic [AW-1:0] wrAddr;
  logic          busy;

  eeprom_prog_ctrl #(.AW(AW), .WORD_CYC(WORD_CYC), .MIN_LOW_CYC(MIN_LOW_CYC)) uCtrl (
    .clk(clk), .rst(rst), .csIn(csIn), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .strb(strb), .wrAddr(wrAddr), .busy(busy),
    .doOut(doOut), .doOe(doOe)
  );

  eeprom_prog_store #(.AW(AW), .DW(DW)) uStore (
    .clk(clk), .rst(rst), .strb(strb), .wrAddr(wrAddr), .cmdData(cmdData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

endmodule

// File: rtl/eeprom_prog_chk.sv
module eeprom_prog_chk #(
  parameter int WORD_CYC = 80
) (
  input logic clk,
  input logic rst,
  input logic csIn,
  input logic doOe,
  input logic doOut,
  input logic busy,
  input logic wrEn
);
  int runLen;

  always_ff @(posedge clk) begin
    if (rst) runLen <= 0;
    else if (busy) runLen <= runLen + 1;
    else runLen <= 0;
  end

  // R3: a cycle begins only after a sampled falling edge of chip select
  a_r3_launch_on_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!$past(csIn) && $past(csIn, 2)));

  // R4: cycle length is one of the three parameterized durations
  a_r4_cycle_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (runLen == WORD_CYC || runLen == 2 * WORD_CYC || runLen == 4 * WORD_CYC));

  // R4: the array is written only inside a running cycle
  a_r4_write_only_busy: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> busy);

  // R9: status drive drops after chip select falls
  a_r9_hiz_after_low: assert property (@(posedge clk) disable iff (rst)
    !$past(csIn) |-> !doOe);

  // R8: while driven, status tracks the busy state
  a_r8_status_value: assert property (@(posedge clk) disable iff (rst)
    doOe |-> (doOut != busy));

endmodule

bind eeprom_prog_engine eeprom_prog_chk #(.WORD_CYC(WORD_CYC)) uChk (
  .clk(clk), .rst(rst), .csIn(csIn), .doOe(doOe), .doOut(doOut),
  .busy(busy), .wrEn(strb.wrEn)
);

// File: tb/sim_eeprom_prog_engine.sv
module sim_eeprom_prog_engine;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int W  = 10;
  localparam int ML = 3;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          csIn = 1'b0;
  logic          cmdValid = 1'b0;
  logic [2:0]    cmdOp = '0;
  logic [AW-1:0] cmdAddr = '0;
  logic [DW-1:0] cmdData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [DW-1:0] rdData;
  logic          doOut, doOe;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] model [DEPTH];
  logic en = 1'b0;

  always #2 clk = ~clk;

  eeprom_prog_engine #(.AW(AW), .DW(DW), .WORD_CYC(W), .MIN_LOW_CYC(ML)) u0 (
    .clk(clk), .rst(rst), .csIn(csIn), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .rdAddr(rdAddr), .rdData(rdData),
    .doOut(doOut), .doOe(doOe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int durOf(input logic [2:0] op);
    if (op == 3'd5) return 2 * W;
    if (op == 3'd6) return 4 * W;
    return W;
  endfunction

  task automatic sendCmd(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdData = d;
    tick(1);
    cmdValid = 1'b0;
  endtask

  task automatic applyModel(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    case (op)
      3'd3: model[a] = '1;
      3'd4: model[a] = d;
      3'd5: for (int i = 0; i < DEPTH; i++) model[i] = '1;
      3'd6: for (int i = 0; i < DEPTH; i++) model[i] = d;
      default: ;
    endcase
  endtask

  task automatic checkMem(input string req);
    for (int i = 0; i < DEPTH; i++) begin
      rdAddr = AW'(i);
      #1;
      check(req, 32'(rdData), 32'(model[i]));
    end
    tick(1);
  endtask

  // Program op with status polling; optional intruding command mid-cycle
  task automatic runProg(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic intrude, input logic [2:0] iop);
    int n;
    logic expLaunch;
    expLaunch = en;
    csIn = 1'b1; rdAddr = a;
    tick(1);
    sendCmd(op, a, d);
    csIn = 1'b0; n = 0;
    tick(4); n = 4;
    csIn = 1'b1;
    tick(1); n = 5;
    check("R8 status drive after long low", 32'(doOe), 32'(expLaunch));
    if (expLaunch) begin
      check("R8 busy shows 0", 32'(doOut), 32'd0);
      if (op == 3'd4) check("R6 word reads ones mid-cycle", 32'(rdData), 32'(DW'('1)));
      if (intrude) begin
        sendCmd(iop, ~a, ~d); n++;
      end
      while (doOut == 1'b0 && n < 200) begin
        tick(1); n++;
      end
      check("R4 cycle length", 32'(n), 32'(durOf(op) + 1));
      applyModel(op, a, d);
    end
    csIn = 1'b0;
    tick(1);
    check("R9 hi-z after fall", 32'(doOe), 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    tick(3);
    rst = 1'b0;
    tick(1);
    check("R1 reset output enable", 32'(doOe), 32'd0);

    // R1/R2: write while disabled is discarded, no status afterwards
    runProg(3'd6, '0, 8'h00, 1'b0, 3'd0);
    check("R2 disabled no drive", 32'(doOe), 32'd0);

    // enable, then initialize the whole array with write-all (R7)
    csIn = 1'b1; tick(1); sendCmd(3'd1, '0, '0); en = 1'b1;
    runProg(3'd6, '0, 8'hA5, 1'b0, 3'd0);
    checkMem("R7 write all");
    runProg(3'd5, '0, 8'h00, 1'b0, 3'd0);
    checkMem("R7 erase all");
    runProg(3'd4, 4'd3, 8'h3C, 1'b0, 3'd0);
    checkMem("R6 write word");
    runProg(3'd3, 4'd3, 8'h00, 1'b0, 3'd0);
    checkMem("R5 erase word");

    // R8: too-short low time gives no status; cycle still completes (R4)
    csIn = 1'b1; tick(1);
    sendCmd(3'd4, 4'd9, 8'h5A);
    csIn = 1'b0; tick(1);
    csIn = 1'b1; tick(1);
    check("R8 short low no drive", 32'(doOe), 32'd0);
    tick(3 * W);
    csIn = 1'b0; tick(5);
    csIn = 1'b1; tick(1);
    check("R8 no relaunch no drive", 32'(doOe), 32'd0);
    applyModel(3'd4, 4'd9, 8'h5A);
    csIn = 1'b0; tick(1);
    checkMem("R4 completes without cs");

    // R10: intruders during busy (incl. disable) ignored
    runProg(3'd4, 4'd1, 8'h11, 1'b1, 3'd2);
    runProg(3'd4, 4'd2, 8'h22, 1'b0, 3'd0);
    checkMem("R10 intruder ignored");

    // R2: disable then write discarded, read still works
    csIn = 1'b1; tick(1); sendCmd(3'd2, '0, '0); en = 1'b0;
    runProg(3'd4, 4'd5, 8'h77, 1'b0, 3'd0);
    checkMem("R2 read while disabled");

    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [2:0] op;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      op = 3'($urandom % 8);
      a  = AW'($urandom);
      d  = DW'($urandom);
      if (op == 3'd1 || op == 3'd2) begin
        csIn = 1'b1; tick(1); sendCmd(op, a, d);
        en = (op == 3'd1);
        csIn = 1'b0; tick(1);
      end else if (op >= 3'd3 && op <= 3'd6) begin
        runProg(op, a, d, ($urandom % 2) == 1, 3'($urandom % 8));
        checkMem("R3 random program");
      end else begin
        csIn = 1'b1; tick(1); sendCmd(op, a, d);
        csIn = 1'b0; tick(2);
        check("R2 no-op no drive", 32'(doOe), 32'd0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule